// File: doc/BRIEF.md
# HDLC Control Field Extractor and Packer

This block sits behind the receive address filter of an HDLC receiver. It takes the octets of one received frame, from the octet after the opening flag to the last check-sequence octet. It decides how long the control field is and packs the header and payload into 16-bit words for a DMA write port. Each word goes out with its index inside the frame, and the last word of the frame carries an end marker. The trailing check-sequence octets never reach the port.

Four configuration bits set the header handling: extended control, forced control extension, promiscuous, and no-extraction. A fifth input, from the address filter, says whether the received address was one octet or two. With promiscuous off, the address octets are consumed without being stored. With promiscuous on, the address is stored in word 0. With promiscuous and no-extraction both on, the block works as a raw pipe: it packs every octet as data and interprets nothing. A single-octet address or control field is stored by copying it into both bytes of one word. A field of two octets is stored with its first octet in the low byte.

Top module: `hdlc_ctl_packer`

## Requirements
- R1: With `cfg_ext_ctrl` low, the control field is one octet C, stored as the word {C, C}.
- R2: With `cfg_ext_ctrl` high and `cfg_force_ctrl` low, a first control octet C0 whose bits [1:0] are not 2'b11 starts a two-octet control field {C1, C0} (C1 in bits [15:8]). When bits [1:0] are 2'b11, the control field is the single octet C0, stored as {C0, C0}.
- R3: With `cfg_ext_ctrl` and `cfg_force_ctrl` both high, the control field is always two octets, whatever the value of C0.
- R4: With `cfg_ext_ctrl` low, `cfg_force_ctrl` has no effect: the control field stays one octet.
- R5: With `cfg_prom` low, the address octets are not written. There are two of them when `cfg_addr_wide` is high and one otherwise. The control field is written as word 0. `cfg_no_extract` has no effect in this mode.
- R6: With `cfg_prom` high and `cfg_no_extract` low, the address is written as word 0 and the control field as word 1. A one-octet address A is written as {A, A`}; a two-octet address is written as {A1, A0}.
- R7: With `cfg_prom` and `cfg_no_extract` both high, every stored octet is payload, packed from word 0 with no header interpretation.
- R8: The final `FCS_LEN` octets of a frame (the one flagged by `in_eof` and the ones before it) are never written.
- R9: Payload octets are packed in pairs with the earlier octet in bits [7:0]. A trailing odd octet P is written as {8'h00, P}.
- R10: Each frame's words carry `wr_index` values 0, 1, 2, … in order. Only the last word of the frame has `wr_last` high, and the next frame restarts at index 0.
- R11: After reset, `wr_valid`, `wr_last`, `wr_data` and `wr_index` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext_ctrl | input | 1 | Extended (modulo-128) control field enable |
| cfg_force_ctrl | input | 1 | Force a two-octet control field when extended control is on |
| cfg_prom | input | 1 | Promiscuous: store the address field |
| cfg_no_extract | input | 1 | With `cfg_prom`, store the whole frame as raw data |
| cfg_addr_wide | input | 1 | Address of the current frame is two octets (from the address filter) |
| in_valid | input | 1 | Octet strobe |
| in_data | input | 8 | Received octet |
| in_eof | input | 1 | Marks the last check-sequence octet of the frame |
| wr_valid | output | 1 | Word strobe |
| wr_data | output | 16 | Packed word |
| wr_index | output | IDX_W | Word index within the frame |
| wr_last | output | 1 | Last word of the frame |

## Verification
The assertions assume four things about the inputs:
- The configuration bits and `cfg_addr_wide` stay constant while a frame is in flight.
- `in_valid` is low in the cycle after `in_eof`. This is the closing flag time, and the packer uses it to emit a deferred last word.
- Every frame holds more than `FCS_LEN` octets.
- Every frame holds at least its full address and control header, except in raw mode.

The bench changes configuration only between frames, after the output has drained. It always leaves idle cycles after each end marker, and it builds every frame with a complete header and two check octets.

// File: rtl/hdlc_ctl_pkg.sv
package hdlc_ctl_pkg;
  localparam int OCT_W  = 8;
  localparam int WORD_W = 2 * OCT_W;

  // how one released octet is routed into the word packer
  typedef enum logic [1:0] {K_SKIP, K_DUP, K_PAIR} oct_kind_e;

  // header walk; H_START covers the first body octet of a frame
  typedef enum logic [2:0] {H_START, H_ADDR_HI, H_CTL_LO, H_CTL_HI, H_BODY} hdr_state_e;

  function automatic logic ctl_is_wide(input logic [OCT_W-1:0] c0,
                                       input logic ext, input logic force_ext);
    return ext && (force_ext || ((c0 & 8'h03) != 8'h03));
  endfunction

  function automatic logic [WORD_W-1:0] dup_word(input logic [OCT_W-1:0] b);
    return {b, b};
  endfunction

  function automatic logic [WORD_W-1:0] pair_word(input logic [OCT_W-1:0] hi,
                                                  input logic [OCT_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [WORD_W-1:0] odd_word(input logic [OCT_W-1:0] lo);
    return {{OCT_W{1'b0}}, lo};
  endfunction
endpackage

// File: rtl/fcs_holdback.sv
module fcs_holdback
  import hdlc_ctl_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OCT_W-1:0] in_data,
  input  logic             in_eof,
  output logic             rel_valid,
  output logic [OCT_W-1:0] rel_octet,
  output logic             frame_end
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [OCT_W-1:0] line [DEPTH];
  logic [CNT_W-1:0] fill;

  // an octet leaves only once DEPTH newer octets sit behind it
  assign rel_valid = in_valid && (fill == CNT_W'(DEPTH));
  assign rel_octet = line[0];
  assign frame_end = in_valid && in_eof;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
      for (int k = 0; k < DEPTH; k++) line[k] <= '0;
    end else if (in_valid) begin
      for (int k = 0; k < DEPTH - 1; k++) line[k] <= line[k+1];
      line[DEPTH-1] <= in_data;
      if (in_eof)                      fill <= '0;
      else if (fill != CNT_W'(DEPTH))  fill <= fill + CNT_W'(1);
    end
  end

  AST_FCS_NOT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !rel_valid); // R8
endmodule

// File: rtl/hdr_classify.sv
module hdr_classify
  import hdlc_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rel_valid,
  input  logic [OCT_W-1:0] rel_octet,
  input  logic             frame_end,
  input  logic             cfg_ext_ctrl,
  input  logic             cfg_force_ctrl,
  input  logic             cfg_prom,
  input  logic             cfg_no_extract,
  input  logic             cfg_addr_wide,
  output oct_kind_e        kind
);
  hdr_state_e st, st_nxt;
  logic       raw_mode;

  assign raw_mode = cfg_prom && cfg_no_extract;

  always_comb begin
    kind   = K_PAIR;
    st_nxt = H_BODY;
    unique case (st)
      H_START: begin
        if (raw_mode) begin
          kind   = K_PAIR;
          st_nxt = H_BODY;
        end else begin
          kind   = !cfg_prom ? K_SKIP : (cfg_addr_wide ? K_PAIR : K_DUP);
          st_nxt = cfg_addr_wide ? H_ADDR_HI : H_CTL_LO;
        end
      end
      H_ADDR_HI: begin
        kind   = cfg_prom ? K_PAIR : K_SKIP;
        st_nxt = H_CTL_LO;
      end
      H_CTL_LO: begin
        if (ctl_is_wide(rel_octet, cfg_ext_ctrl, cfg_force_ctrl)) begin
          kind   = K_PAIR;
          st_nxt = H_CTL_HI;
        end else begin
          kind   = K_DUP;
          st_nxt = H_BODY;
        end
      end
      H_CTL_HI: begin
        kind   = K_PAIR;
        st_nxt = H_BODY;
      end
      default: begin
        kind   = K_PAIR;
        st_nxt = H_BODY;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         st <= H_START;
    else if (frame_end) st <= H_START;
    else if (rel_valid) st <= st_nxt;
  end

  AST_NARROW_CTL_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ext_ctrl |-> (st != H_CTL_HI)); // R1
  AST_FORCED_CTL_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !frame_end && st == H_CTL_LO && cfg_ext_ctrl && cfg_force_ctrl)
      |=> (st == H_CTL_HI)); // R3
endmodule

// File: rtl/word_packer.sv
module word_packer
  import hdlc_ctl_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oct_valid,
  input  logic [OCT_W-1:0]  oct,
  input  oct_kind_e         kind,
  input  logic              frame_end,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_data,
  output logic [IDX_W-1:0]  wr_index,
  output logic              wr_last
);
  logic [WORD_W-1:0] pend_w, tail_w, nw, fin_w, emit_w;
  logic              pend_v, tail_v, nw_v, fin_v, emit_v, emit_last;
  logic [OCT_W-1:0]  half_b, half_n;
  logic              half_v, halfv_n;
  logic [IDX_W-1:0]  widx;

  // word completion from the incoming octet
  always_comb begin
    nw_v    = 1'b0;
    nw      = '0;
    half_n  = half_b;
    halfv_n = half_v;
    if (oct_valid) begin
      unique case (kind)
        K_DUP: begin
          nw_v = 1'b1;
          nw   = dup_word(oct);
        end
        K_PAIR: begin
          if (half_v) begin
            nw_v    = 1'b1;
            nw      = pair_word(oct, half_b);
            halfv_n = 1'b0;
          end else begin
            half_n  = oct;
            halfv_n = 1'b1;
          end
        end
        default: ;
      endcase
    end
    fin_v = nw_v || halfv_n;
    fin_w = nw_v ? nw : odd_word(half_n);
  end

  // one word leaves per cycle; a word is held until it is known whether it is last
  always_comb begin
    emit_v    = 1'b0;
    emit_w    = pend_w;
    emit_last = 1'b0;
    if (tail_v) begin
      emit_v    = 1'b1;
      emit_w    = tail_w;
      emit_last = 1'b1;
    end else if (frame_end) begin
      if (pend_v) begin
        emit_v    = 1'b1;
        emit_w    = pend_w;
        emit_last = !fin_v;
      end else if (fin_v) begin
        emit_v    = 1'b1;
        emit_w    = fin_w;
        emit_last = 1'b1;
      end
    end else if (nw_v && pend_v) begin
      emit_v = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_data  <= '0;
      wr_index <= '0;
      wr_last  <= 1'b0;
      widx     <= '0;
      pend_w   <= '0;
      pend_v   <= 1'b0;
      tail_w   <= '0;
      tail_v   <= 1'b0;
      half_b   <= '0;
      half_v   <= 1'b0;
    end else begin
      wr_valid <= emit_v;
      wr_last  <= emit_v && emit_last;
      if (emit_v) begin
        wr_data  <= emit_w;
        wr_index <= widx;
        widx     <= emit_last ? '0 : widx + IDX_W'(1);
      end
      tail_v <= frame_end && pend_v && fin_v;
      if (frame_end) tail_w <= fin_w;
      if (frame_end) begin
        pend_v <= 1'b0;
        half_v <= 1'b0;
      end else begin
        half_b <= half_n;
        half_v <= halfv_n;
        if (nw_v) begin
          pend_w <= nw;
          pend_v <= 1'b1;
        end
      end
    end
  end

  AST_DUP_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (oct_valid && kind == K_DUP) |-> !half_v); // R1
  AST_TAIL_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tail_v |-> (!oct_valid && !frame_end)); // R10
  AST_LAST_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_last) |=> !wr_valid); // R10
endmodule

// File: rtl/hdlc_ctl_packer.sv
module hdlc_ctl_packer
  import hdlc_ctl_pkg::*;
#(
  parameter int FCS_LEN = 2,
  parameter int IDX_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ext_ctrl,
  input  logic             cfg_force_ctrl,
  input  logic             cfg_prom,
  input  logic             cfg_no_extract,
  input  logic             cfg_addr_wide,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_eof,
  output logic             wr_valid,
  output logic [15:0]      wr_data,
  output logic [IDX_W-1:0] wr_index,
  output logic             wr_last
);
  logic             rel_valid, frame_end;
  logic [OCT_W-1:0] rel_octet;
  oct_kind_e        kind;

  fcs_holdback #(.DEPTH(FCS_LEN)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_eof(in_eof),
    .rel_valid(rel_valid), .rel_octet(rel_octet), .frame_end(frame_end)
  );

  hdr_classify u_cls (
    .clk(clk), .rst_n(rst_n),
    .rel_valid(rel_valid), .rel_octet(rel_octet), .frame_end(frame_end),
    .cfg_ext_ctrl(cfg_ext_ctrl), .cfg_force_ctrl(cfg_force_ctrl),
    .cfg_prom(cfg_prom), .cfg_no_extract(cfg_no_extract),
    .cfg_addr_wide(cfg_addr_wide), .kind(kind)
  );

  word_packer #(.IDX_W(IDX_W)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .oct_valid(rel_valid), .oct(rel_octet), .kind(kind), .frame_end(frame_end),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_index(wr_index), .wr_last(wr_last)
  );

  AST_RAW_ALL_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_prom && cfg_no_extract && rel_valid) |-> (kind == K_PAIR)); // R7
  AST_FILTERED_ADDR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_prom && rel_valid && kind == K_SKIP) |=> !(wr_valid && wr_index == '0 && wr_last)); // R5
endmodule

// File: tb/hdlc_ctl_packer_bench.sv
module hdlc_ctl_packer_bench;
  localparam int IDX_W = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_ext_ctrl = 0, cfg_force_ctrl = 0, cfg_prom = 0, cfg_no_extract = 0, cfg_addr_wide = 0;
  logic in_valid = 0, in_eof = 0;
  logic [7:0] in_data = '0;
  logic wr_valid, wr_last;
  logic [15:0] wr_data;
  logic [IDX_W-1:0] wr_index;

  int checks = 0, fails = 0;
  bit done = 0, live = 0;

  logic [15:0] exp_w[$];
  int          exp_i[$];
  bit          exp_l[$];
  string       exp_r[$];

  always #2 clk = ~clk;

  hdlc_ctl_packer #(.FCS_LEN(2), .IDX_W(IDX_W)) u_hdlc_ctl_packer (
    .clk(clk), .rst_n(rst_n),
    .cfg_ext_ctrl(cfg_ext_ctrl), .cfg_force_ctrl(cfg_force_ctrl),
    .cfg_prom(cfg_prom), .cfg_no_extract(cfg_no_extract), .cfg_addr_wide(cfg_addr_wide),
    .in_valid(in_valid), .in_data(in_data), .in_eof(in_eof),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_index(wr_index), .wr_last(wr_last)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  // reference: list of words a frame must produce
  task automatic model(input logic [7:0] f[$], input string rq);
    logic [7:0] b[$];
    logic [15:0] w[$];
    int i, clen;
    b = f[0:f.size()-3];             // check-sequence octets dropped (R8)
    i = 0;
    if (!(cfg_prom && cfg_no_extract)) begin
      if (cfg_prom) begin
        if (cfg_addr_wide) w.push_back({b[1], b[0]});
        else               w.push_back({b[0], b[0]});
      end
      i = cfg_addr_wide ? 2 : 1;
      clen = 1;
      if (cfg_ext_ctrl && (cfg_force_ctrl || b[i][1:0] != 2'b11)) clen = 2;
      if (clen == 1) w.push_back({b[i], b[i]});
      else           w.push_back({b[i+1], b[i]});
      i += clen;
    end
    while (i < b.size()) begin
      if (i + 1 < b.size()) w.push_back({b[i+1], b[i]});
      else                  w.push_back({8'h00, b[i]});
      i += 2;
    end
    foreach (w[k]) begin
      exp_w.push_back(w[k]);
      exp_i.push_back(k);
      exp_l.push_back(k == w.size() - 1);
      exp_r.push_back(rq);
    end
  endtask

  task automatic set_mode(input bit ext, input bit frc, input bit prom, input bit noex, input bit wide);
    cfg_ext_ctrl = ext; cfg_force_ctrl = frc; cfg_prom = prom;
    cfg_no_extract = noex; cfg_addr_wide = wide;
  endtask

  task automatic send(input logic [7:0] f[$], input string rq);
    model(f, rq);
    foreach (f[k]) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = f[k];
      in_eof   = (k == f.size() - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_eof   = 1'b0;
    repeat (4) @(negedge clk);
    chk(exp_w.size() == 0, rq, "words missing at frame end", exp_w.size(), 0);
  endtask

  // per-clock comparison against the reference queue
  always @(negedge clk) begin
    if (live) begin
      if (wr_valid) begin
        if (exp_w.size() == 0) begin
          chk(1'b0, "R10", "unexpected word", wr_data, 0);
        end else begin
          logic [15:0] ew; int ei; bit el; string er;
          ew = exp_w.pop_front(); ei = exp_i.pop_front();
          el = exp_l.pop_front(); er = exp_r.pop_front();
          chk(wr_data == ew, er, "data", wr_data, ew);
          chk(int'(wr_index) == ei, {er, "/R10"}, "index", wr_index, ei);
          chk(wr_last == el, {er, "/R10"}, "last", wr_last, el);
        end
      end else begin
        chk(!wr_last, "R10", "last without valid", wr_last, 0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!wr_valid && !wr_last && wr_data == 0 && wr_index == 0, "R11", "reset outputs",
        {wr_valid, wr_last, wr_data, wr_index}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    live = 1;

    set_mode(0, 0, 0, 0, 0);
    send('{8'h03, 8'h00, 8'h11, 8'h22, 8'h33, 8'hE1, 8'hE2}, "R1");
    set_mode(1, 0, 0, 0, 0);
    send('{8'h01, 8'h02, 8'h05, 8'hAA, 8'hBB, 8'hE3, 8'hE4}, "R2");
    send('{8'h01, 8'h13, 8'h44, 8'hE5, 8'hE6}, "R2");
    send('{8'h01, 8'h01, 8'h90, 8'h61, 8'hE7, 8'hE8}, "R2");
    set_mode(1, 1, 0, 0, 0);
    send('{8'h03, 8'h03, 8'h7F, 8'h01, 8'h02, 8'h03, 8'h04, 8'hE9, 8'hEA}, "R3");
    set_mode(0, 1, 0, 0, 0);
    send('{8'h03, 8'h00, 8'h55, 8'hEB, 8'hEC}, "R4");
    set_mode(0, 0, 0, 1, 1);
    send('{8'h02, 8'h81, 8'h0F, 8'h66, 8'h77, 8'hED, 8'hEE}, "R5");
    set_mode(0, 0, 1, 0, 0);
    send('{8'hC5, 8'h3F, 8'h88, 8'hEF, 8'hF0}, "R6");
    set_mode(1, 0, 1, 0, 1);
    send('{8'h02, 8'h81, 8'h04, 8'h09, 8'h99, 8'hF1, 8'hF2}, "R6");
    set_mode(1, 1, 1, 1, 1);
    send('{8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'hF3, 8'hF4}, "R7");
    send('{8'h5A, 8'hF5, 8'hF6}, "R7");
    send('{8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hF7, 8'hF8}, "R9");
    set_mode(0, 0, 0, 0, 0);
    send('{8'h03, 8'h2B, 8'hF9, 8'hFA}, "R8");
    send('{8'h03, 8'h10, 8'hB1, 8'hB2, 8'hB3, 8'hB4, 8'hB5, 8'hFB, 8'hFC}, "R9");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule